// File: doc/BRIEF.md
# Sequencer Start Trigger and Interrupt Controller

This block governs how one conversion sequencer of a two-sequencer ADC controller gets started and how it signals completion to the CPU. Starts come from software, by writing a 1 to a start bit in an 8-bit control register, or from an external PWM start pulse when that source is enabled. The block turns each trigger into a start request toward the conversion arbiter. If the sequencer is already occupied, the block parks one trigger in a single pending latch and drops any further triggers.

When a sequence completes, an interrupt flag is raised. The flag is raised either on every completion or on every second completion. The flag feeds a CPU interrupt request through an enable bit. Software clears the flag with a separate acknowledge strobe. Writing a 0 to the start bit withdraws a pending trigger, but it cannot stop a sequence that is already running.

Top module: `seq_trig_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, `start_req` is 0 and `irq_req` is 0.
- R2: Bit 3 (interrupt enable), bit 2 (interrupt mode) and bit 0 (PWM trigger enable) are written by a register write and read back. Bits 7, 6, 4 and 1 always read 0 and ignore writes.
- R3: A trigger is a register write with bit 5 = 1, or a `pwm_trig` pulse. A trigger that arrives while the sequencer is free and nothing is pending raises `start_req` on the next clock, and bit 5 then reads 0.
- R4: `start_req` stays high until `start_gnt` is seen. It is low on the clock after the grant.
- R5: The sequencer counts as occupied from the rise of `start_req` until the clock after its `seq_done` pulse, and also while `seq_busy` is high. A trigger arriving while the sequencer is occupied sets bit 5 (pending). The pending trigger is launched once the sequencer is free, and bit 5 returns to 0 at that launch.
- R6: A trigger arriving while the sequencer is occupied and bit 5 is already 1 is discarded, and no extra sequence is ever started for it.
- R7: A register write with bit 5 = 0 clears a pending trigger. It has no effect on a sequence already requested or running, and that sequence still completes.
- R8: `pwm_trig` is a trigger only while bit 0 is 1. Otherwise it has no effect.
- R9: A software trigger and a PWM trigger in the same clock cycle count as one trigger.
- R10: With bit 2 = 0 the interrupt flag is set on every `seq_done`. With bit 2 = 1 it is set only on every second `seq_done`. This every-second count is tracked by a toggle that resets to 0, advances on every `seq_done` in either mode, and sets the flag on the pulse that returns it to 0.
- R11: `irq_req` equals the interrupt flag ANDed with bit 3. The flag stays set through further completions until `irq_ack` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 8 | Control register write data |
| reg_rd_data | output | 8 | Control register read data |
| pwm_trig | input | 1 | External PWM start pulse |
| seq_busy | input | 1 | Sequencer running status |
| seq_done | input | 1 | One-cycle end-of-sequence pulse |
| start_req | output | 1 | Start request to the arbiter |
| start_gnt | input | 1 | Arbiter grant for the start request |
| irq_ack | input | 1 | Software acknowledge, clears the interrupt flag |
| irq_req | output | 1 | CPU interrupt request |

## Verification
The hardest case to reach from the ports is a third trigger arriving while the sequencer is occupied and a trigger is already pending. Checking it also needs proof that the dropped trigger never turns into a sequence. A close second is a trigger that lands while a start request is still waiting for its grant. The bench's sequencer model has a programmable grant delay and run length, so the bench can place triggers inside these windows. The bench counts every grant the model issues, which exposes a dropped trigger that was wrongly honoured. It also counts every completion, so the every-second interrupt can be predicted from that count's parity.

// File: rtl/seq_trig_pkg.sv
package seq_trig_pkg;
   localparam int unsigned BIT_START = 5;
   localparam int unsigned BIT_IEN   = 3;
   localparam int unsigned BIT_MODE  = 2;
   localparam int unsigned BIT_PWMEN = 0;
   localparam int unsigned MIN_W     = 6;

   typedef struct packed {
      logic ien;
      logic alt_mode;
      logic pwm_en;
   } ctrl_t;
endpackage

// File: rtl/seq_trig_ctrl_regs.sv
module seq_trig_ctrl_regs
   import seq_trig_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              pend_i,
   output ctrl_t             ctrl_o,
   output logic              sw_trig_o,
   output logic              sw_clr_o,
   output logic [DATA_W-1:0] rd_data_o
);
   ctrl_t ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en_i) begin
         ctrl_q.ien      <= wr_data_i[BIT_IEN];
         ctrl_q.alt_mode <= wr_data_i[BIT_MODE];
         ctrl_q.pwm_en   <= wr_data_i[BIT_PWMEN];
      end
   end

   assign sw_trig_o = wr_en_i &  wr_data_i[BIT_START];
   assign sw_clr_o  = wr_en_i & ~wr_data_i[BIT_START];
   assign ctrl_o    = ctrl_q;

   always_comb begin
      rd_data_o            = '0;
      rd_data_o[BIT_START] = pend_i;
      rd_data_o[BIT_IEN]   = ctrl_q.ien;
      rd_data_o[BIT_MODE]  = ctrl_q.alt_mode;
      rd_data_o[BIT_PWMEN] = ctrl_q.pwm_en;
   end
endmodule

// File: rtl/seq_trig_pwm_in.sv
module seq_trig_pwm_in #(
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_i,
   input  logic en_i,
   output logic trig_o
);
   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign trig_o = pwm_i & en_i;
      end else begin : g_sync
         localparam int unsigned CHAIN_W = SYNC_STAGES + 1;
         logic [CHAIN_W-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CHAIN_W-2:0], pwm_i};
         end
         assign trig_o = en_i & chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
      end
   endgenerate
endmodule

// File: rtl/seq_trig_launch.sv
module seq_trig_launch (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic clr_i,
   input  logic busy_i,
   input  logic done_i,
   input  logic gnt_i,
   output logic req_o,
   output logic pend_o
);
   logic req_q, run_q, pend_q;
   logic pend_base, occupied, launch, pend_d;

   assign pend_base = clr_i ? 1'b0 : pend_q;
   assign occupied  = req_q | run_q | busy_i;
   assign launch    = ~occupied & (pend_base | trig_i);
   assign pend_d    = launch ? (pend_base & trig_i) : (pend_base | trig_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         pend_q <= pend_d;
         if (launch)              req_q <= 1'b1;
         else if (req_q && gnt_i) req_q <= 1'b0;
         if (req_q && gnt_i)      run_q <= 1'b1;
         else if (done_i)         run_q <= 1'b0;
      end
   end

   assign req_o  = req_q;
   assign pend_o = pend_q;
endmodule

// File: rtl/seq_trig_irq.sv
module seq_trig_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic done_i,
   input  logic alt_mode_i,
   input  logic ien_i,
   input  logic ack_i,
   output logic irq_o
);
   logic tog_q, flag_q, set_flag;

   assign set_flag = done_i & (~alt_mode_i | tog_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tog_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         if (done_i)        tog_q  <= ~tog_q;
         if (set_flag)      flag_q <= 1'b1;
         else if (ack_i)    flag_q <= 1'b0;
      end
   end

   assign irq_o = flag_q & ien_i;
endmodule

// File: rtl/seq_trig_irq_ctrl.sv
module seq_trig_irq_ctrl
   import seq_trig_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [DATA_W-1:0] reg_wr_data,
   output logic [DATA_W-1:0] reg_rd_data,
   input  logic              pwm_trig,
   input  logic              seq_busy,
   input  logic              seq_done,
   output logic              start_req,
   input  logic              start_gnt,
   input  logic              irq_ack,
   output logic              irq_req
);
   generate
      if (DATA_W < MIN_W) begin : g_bad_width
         $error("seq_trig_irq_ctrl: DATA_W must be at least 6");
      end
      if (SYNC_STAGES == 1) begin : g_bad_sync
         $error("seq_trig_irq_ctrl: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   ctrl_t ctrl;
   logic  sw_trig, sw_clr, pwm_hit, pend;

   seq_trig_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_en), .wr_data_i(reg_wr_data),
      .pend_i(pend), .ctrl_o(ctrl), .sw_trig_o(sw_trig), .sw_clr_o(sw_clr),
      .rd_data_o(reg_rd_data)
   );

   seq_trig_pwm_in #(.SYNC_STAGES(SYNC_STAGES)) u_pwm (
      .clk(clk), .rst_n(rst_n), .pwm_i(pwm_trig), .en_i(ctrl.pwm_en),
      .trig_o(pwm_hit)
   );

   seq_trig_launch u_launch (
      .clk(clk), .rst_n(rst_n), .trig_i(sw_trig | pwm_hit), .clr_i(sw_clr),
      .busy_i(seq_busy), .done_i(seq_done), .gnt_i(start_gnt),
      .req_o(start_req), .pend_o(pend)
   );

   seq_trig_irq u_irq (
      .clk(clk), .rst_n(rst_n), .done_i(seq_done), .alt_mode_i(ctrl.alt_mode),
      .ien_i(ctrl.ien), .ack_i(irq_ack), .irq_o(irq_req)
   );
endmodule

// File: rtl/seq_trig_irq_ctrl_chk.sv
module seq_trig_irq_ctrl_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr_en,
   input logic [DATA_W-1:0] reg_wr_data,
   input logic [DATA_W-1:0] reg_rd_data,
   input logic              pwm_trig,
   input logic              seq_busy,
   input logic              seq_done,
   input logic              start_req,
   input logic              start_gnt,
   input logic              irq_ack,
   input logic              irq_req
);
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_data[4] == 1'b0) && (reg_rd_data[1] == 1'b0) && (reg_rd_data[DATA_W-1:6] == '0)); // R2
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && !start_gnt |=> start_req); // R4
   AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      start_req && start_gnt |=> !start_req); // R4
   AST_NO_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(start_req) |-> !$past(seq_busy)); // R5
   AST_WR0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en && !reg_wr_data[5] && !pwm_trig |=> !reg_rd_data[5]); // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> reg_rd_data[3]); // R11
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack && !seq_done |=> !irq_req); // R11
endmodule

bind seq_trig_irq_ctrl seq_trig_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
   .reg_rd_data(reg_rd_data), .pwm_trig(pwm_trig), .seq_busy(seq_busy),
   .seq_done(seq_done), .start_req(start_req), .start_gnt(start_gnt),
   .irq_ack(irq_ack), .irq_req(irq_req)
);

// File: tb/seq_trig_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module seq_trig_irq_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wr_data = '0;
   logic [7:0] reg_rd_data;
   logic       pwm_trig = 1'b0;
   logic       seq_busy;
   logic       seq_done;
   logic       start_req;
   logic       start_gnt;
   logic       irq_ack = 1'b0;
   logic       irq_req;

   int n_chk = 0;
   int n_fail = 0;
   int gnt_delay = 0;
   int run_len = 6;
   int wcnt, run_cnt, starts, dones;

   always #10 clk = ~clk;

   seq_trig_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
      .reg_rd_data(reg_rd_data), .pwm_trig(pwm_trig), .seq_busy(seq_busy),
      .seq_done(seq_done), .start_req(start_req), .start_gnt(start_gnt),
      .irq_ack(irq_ack), .irq_req(irq_req)
   );

   // arbiter and sequencer model
   assign seq_busy = (run_cnt != 0);
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_gnt <= 1'b0; seq_done <= 1'b0;
         wcnt <= 0; run_cnt <= 0; starts <= 0; dones <= 0;
      end else begin
         start_gnt <= 1'b0;
         seq_done  <= 1'b0;
         if (start_req && !start_gnt) begin
            if (wcnt >= gnt_delay) begin start_gnt <= 1'b1; wcnt <= 0; end
            else wcnt <= wcnt + 1;
         end
         if (start_gnt && start_req) begin
            run_cnt <= run_len;
            starts  <= starts + 1;
         end else if (run_cnt != 0) begin
            run_cnt <= run_cnt - 1;
            if (run_cnt == 1) begin seq_done <= 1'b1; dones <= dones + 1; end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] d);
      @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
      @(negedge clk); reg_wr_en = 1'b0; reg_wr_data = '0;
   endtask

   task automatic pwm_pulse();
      @(negedge clk); pwm_trig = 1'b1;
      @(negedge clk); pwm_trig = 1'b0;
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(reg_rd_data == 8'h00, "R1 reg", reg_rd_data, 0);
      chk(start_req == 1'b0, "R1 start_req", start_req, 0);
      chk(irq_req == 1'b0, "R1 irq_req", irq_req, 0);
   endtask

   task automatic t_regs();
      wr(8'hDF);
      chk(reg_rd_data == 8'h0D, "R2 fields/reserved", reg_rd_data, 8'h0D);
      chk(start_req == 1'b0, "R2 no start", start_req, 0);
      wr(8'h00);
      chk(reg_rd_data == 8'h00, "R2 clear", reg_rd_data, 0);
   endtask

   task automatic t_idle_start();
      int s0 = starts;
      gnt_delay = 3;
      wr(8'h20);
      chk(start_req == 1'b1, "R3 req raised", start_req, 1);
      chk(reg_rd_data[5] == 1'b0, "R3 start bit clear", reg_rd_data[5], 0);
      idle(3);
      chk(start_req == 1'b1, "R4 held before grant", start_req, 1);
      while (!start_gnt) @(negedge clk);
      @(negedge clk);
      chk(start_req == 1'b0, "R4 drop after grant", start_req, 0);
      idle(20);
      chk(starts - s0 == 1, "R3 one sequence", starts - s0, 1);
      gnt_delay = 0;
   endtask

   task automatic t_pending_drop();
      int s0 = starts;
      gnt_delay = 2;
      wr(8'h20);
      wr(8'h20); // arrives while request awaits grant
      chk(reg_rd_data[5] == 1'b1, "R5 pending set", reg_rd_data[5], 1);
      wr(8'h20); // dropped
      chk(reg_rd_data[5] == 1'b1, "R6 still one pending", reg_rd_data[5], 1);
      idle(50);
      chk(starts - s0 == 2, "R6 extra trigger dropped", starts - s0, 2);
      chk(reg_rd_data[5] == 1'b0, "R5 pending cleared at launch", reg_rd_data[5], 0);
      gnt_delay = 0;
   endtask

   task automatic t_no_abort();
      int s0 = starts;
      int d0 = dones;
      wr(8'h20);
      idle(3);
      wr(8'h20);
      chk(reg_rd_data[5] == 1'b1, "R7 pending before clear", reg_rd_data[5], 1);
      wr(8'h00);
      chk(reg_rd_data[5] == 1'b0, "R7 pending withdrawn", reg_rd_data[5], 0);
      idle(30);
      chk(starts - s0 == 1, "R7 only running sequence", starts - s0, 1);
      chk(dones - d0 == 1, "R7 running sequence completes", dones - d0, 1);
   endtask

   task automatic t_pwm_gate();
      int s0 = starts;
      wr(8'h00);
      pwm_pulse();
      chk(start_req == 1'b0, "R8 disabled pwm no req", start_req, 0);
      idle(20);
      chk(starts - s0 == 0, "R8 disabled pwm no sequence", starts - s0, 0);
      wr(8'h01);
      pwm_pulse();
      chk(start_req == 1'b1, "R8 enabled pwm req", start_req, 1);
      idle(20);
      chk(starts - s0 == 1, "R8 enabled pwm sequence", starts - s0, 1);
   endtask

   task automatic t_same_cycle();
      int s0 = starts;
      wr(8'h01);
      @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = 8'h21; pwm_trig = 1'b1;
      @(negedge clk); reg_wr_en = 1'b0; reg_wr_data = '0; pwm_trig = 1'b0;
      chk(reg_rd_data[5] == 1'b0, "R9 no pending from merged trigger", reg_rd_data[5], 0);
      idle(30);
      chk(starts - s0 == 1, "R9 merged trigger one sequence", starts - s0, 1);
      wr(8'h00);
   endtask

   task automatic t_irq_every();
      wr(8'h08);
      ack();
      wr(8'h28);
      idle(20);
      chk(irq_req == 1'b1, "R10 mode0 flag each done", irq_req, 1);
      wr(8'h28);
      idle(20);
      chk(irq_req == 1'b1, "R11 held until ack", irq_req, 1);
      ack();
      chk(irq_req == 1'b0, "R11 ack clears", irq_req, 0);
      wr(8'h20);
      idle(20);
      chk(irq_req == 1'b0, "R11 disabled request", irq_req, 0);
      wr(8'h08);
      chk(irq_req == 1'b1, "R11 flag kept while disabled", irq_req, 1);
      ack();
   endtask

   task automatic t_irq_alt();
      wr(8'h0C);
      ack();
      for (int i = 0; i < 3; i++) begin
         bit exp;
         wr(8'h2C);
         idle(20);
         exp = (dones % 2) == 0;
         chk(irq_req == exp, "R10 mode1 every second done", irq_req, exp);
         ack();
      end
      wr(8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regs();
      t_idle_start();
      t_pending_drop();
      t_no_abort();
      t_pwm_gate();
      t_same_cycle();
      t_irq_every();
      t_irq_alt();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule